// File: doc/BRIEF.md
# PWM Timebase with Conversion-Start Trigger

This block is an up-counting pulse-width timebase. A prescaler built from two cascaded dividers turns the system clock into a timebase tick. On each tick the counter steps from zero to a programmed period and then wraps. A single output is driven high at the start of each period and low when the counter meets a compare value. The compare value is double-buffered, so a new duty cycle written in the middle of a period takes effect only at the next period boundary.

Next to the output, the block produces a start-of-conversion pulse for an analog sampling sequencer. The pulse comes from a selectable counter event: counter at zero, counter at period, or counter at compare. An event prescaler lets only every n-th selected event through. The pulse lasts one timebase cycle, and it is gated off while its enable is low. A freeze mode stops the counter, so no events occur and the output holds its level.

Top module: `pwm_soc_timebase`

## Requirements
- R1: While running, the counter advances by one on each timebase tick from 0 up to `period_i`. On the tick where the count is at or above `period_i`, it returns to 0. One period therefore lasts `period_i`+1 timebase cycles.
- R2: `mode_i` = 0 is freeze and `mode_i` = 1 is count-up. In freeze, the counter holds its value, `pwm_o` keeps its level and no trigger pulse is produced.
- R3: One timebase cycle lasts H*G system clocks. H is 1 when `hs_div_i` = 0 and 2*`hs_div_i` otherwise. G is 2 to the power `gen_div_i`.
- R4: `cmp_i` is copied into the active compare register only on the tick that returns the counter to 0, and while reset is asserted. A change of `cmp_i` during a period does not alter that period's duty.
- R5: `pwm_o` goes high on the tick that ends counter state 0 and goes low on the tick that ends counter state equal to the active compare. It is therefore high for `cmp_i` timebase cycles per period. When `cmp_i` > `period_i` it stays high.
- R6: When the compare value is 0, the clear action wins over the set action, so `pwm_o` stays low (0% duty).
- R7: `trig_src_i` selects the counted event: 0 = counter equals 0, 1 = counter equals period, 2 = counter equals active compare, 3 = no event.
- R8: `trig_div_i` = n (1..3) produces a pulse on every n-th selected event. A value of 0 produces no pulses.
- R9: `soc_o` rises on the tick of the event that completes the count and stays high for exactly one timebase cycle. It is low whenever `trig_en_i` is 0.
- R10: The event count is cleared while `trig_en_i` is 0. After re-enabling with n = 2, the first zero event gives no pulse and the second does.
- R11: After a synchronous reset, `pwm_o` and `soc_o` are 0 and the counter is at 0. The first tick after reset release is handled as a counter-zero event.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| period_i | input | CNT_W | Period value (last count before wrap) |
| cmp_i | input | CNT_W | Compare value, shadow side |
| mode_i | input | 1 | 0 freeze, 1 count up |
| hs_div_i | input | HS_W | High-speed divider select |
| gen_div_i | input | GEN_W | General divider select (power of two) |
| trig_en_i | input | 1 | Conversion-trigger enable |
| trig_src_i | input | 2 | Trigger event source select |
| trig_div_i | input | EVP_W | Events per trigger pulse |
| pwm_o | output | 1 | PWM output |
| soc_o | output | 1 | Start-of-conversion pulse |

## Verification
Both outputs are registered on the system-clock edge that carries a timebase tick. A result caused by the counter state in one timebase cycle therefore shows up one system clock after that cycle's final edge, and the bench samples on the falling edge in between. Duty and trigger checks reset the block, wait three full periods so that the shadow compare and the event prescaler are settled, and then count high cycles over a window of twelve periods, which is a whole multiple of every trigger prescale. The shadow-load and re-enable checks instead sync to the falling-edge sample in which `pwm_o` first reads high, and count period boundaries from there.

// File: rtl/pwm_soc_pkg.sv
package pwm_soc_pkg;

    typedef enum logic {
        TB_FREEZE = 1'b0,
        TB_UP     = 1'b1
    } tb_mode_e;

    typedef enum logic [1:0] {
        EV_ZERO   = 2'd0,
        EV_PERIOD = 2'd1,
        EV_CMP    = 2'd2,
        EV_NONE   = 2'd3
    } ev_src_e;

    // Counter events, valid on a running tick
    typedef struct packed {
        logic at_zero;
        logic at_period;
        logic at_cmp;
    } tb_events_t;

    function automatic int hs_ratio(int sel);
        return (sel == 0) ? 1 : 2 * sel;
    endfunction

    function automatic int gen_ratio(int sel);
        return 1 << sel;
    endfunction

endpackage

// File: rtl/tb_prescaler.sv
module tb_prescaler
    import pwm_soc_pkg::*;
#(
    parameter int HS_W  = 3,
    parameter int GEN_W = 3
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [HS_W-1:0]  hs_sel,
    input  logic [GEN_W-1:0] gen_sel,
    output logic             tick
);
    localparam int MAX_DIV = hs_ratio((1 << HS_W) - 1) * gen_ratio((1 << GEN_W) - 1);
    localparam int PRE_W   = $clog2(MAX_DIV + 1);

    logic [PRE_W-1:0] pre_cnt;
    logic [PRE_W-1:0] div_val;
    logic [PRE_W-1:0] div_m1;
    logic [HS_W:0]    hs_fac;

    always_comb begin
        hs_fac  = (hs_sel == '0) ? (HS_W+1)'(1) : {hs_sel, 1'b0};
        div_val = PRE_W'(hs_fac) << gen_sel;
        div_m1  = div_val - PRE_W'(1);
        tick    = (pre_cnt >= div_m1);
    end

    always_ff @(posedge clk) begin
        if (rst)       pre_cnt <= '0;
        else if (tick) pre_cnt <= '0;
        else           pre_cnt <= pre_cnt + PRE_W'(1);
    end

    // R3: with a steady divider selection the count stays inside one timebase cycle
    assert_pre_in_range_R3: assert property (@(posedge clk) disable iff (rst)
        ($stable(hs_sel) && $stable(gen_sel)) |-> (pre_cnt <= div_m1));

endmodule

// File: rtl/tb_counter.sv
module tb_counter
    import pwm_soc_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             run,
    input  logic [CNT_W-1:0] period,
    input  logic [CNT_W-1:0] cmp_shadow,
    output logic             step,
    output tb_events_t       ev
);
    logic [CNT_W-1:0] cnt;
    logic [CNT_W-1:0] cmp_act;
    logic             wrap;

    always_comb begin
        step         = tick && run;
        wrap         = (cnt >= period);
        ev.at_zero   = (cnt == '0);
        ev.at_period = (cnt == period);
        ev.at_cmp    = (cnt == cmp_act);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cnt     <= '0;
            cmp_act <= cmp_shadow;
        end else if (step) begin
            if (wrap) begin
                cnt     <= '0;
                cmp_act <= cmp_shadow;
            end else begin
                cnt <= cnt + CNT_W'(1);
            end
        end
    end

    // R1: a running tick at or past the period returns the count to zero
    assert_wrap_R1: assert property (@(posedge clk) disable iff (rst)
        (step && (cnt >= period)) |=> (cnt == '0));

    // R2: without a running tick the counter holds
    assert_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(cnt));

    // R4: the active compare changes only as the counter lands on zero
    assert_shadow_load_R4: assert property (@(posedge clk) disable iff (rst)
        !$stable(cmp_act) |-> (cnt == '0));

endmodule

// File: rtl/tb_action.sv
module tb_action (
    input  logic clk,
    input  logic rst,
    input  logic step,
    input  logic at_zero,
    input  logic at_cmp,
    output logic pwm
);
    always_ff @(posedge clk) begin
        if (rst)            pwm <= 1'b0;
        else if (step) begin
            if (at_cmp)     pwm <= 1'b0;   // clear wins over set
            else if (at_zero) pwm <= 1'b1;
        end
    end

    // R5, R6: a compare match on a running tick always leaves the output low
    assert_clear_prio_R6: assert property (@(posedge clk) disable iff (rst)
        (step && at_cmp) |=> !pwm);

    // R5: the output only moves on a running tick
    assert_moves_on_step_R5: assert property (@(posedge clk) disable iff (rst)
        !step |=> $stable(pwm));

endmodule

// File: rtl/tb_soc_gen.sv
module tb_soc_gen
    import pwm_soc_pkg::*;
#(
    parameter int EVP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             tick,
    input  logic             step,
    input  tb_events_t       ev,
    input  logic             en,
    input  logic [1:0]       src,
    input  logic [EVP_W-1:0] div,
    output logic             soc
);
    logic [EVP_W-1:0] evt_cnt;
    logic [EVP_W:0]   evt_next;
    logic             sel_ev;
    logic             fire;
    logic             soc_q;

    always_comb begin
        unique case (ev_src_e'(src))
            EV_ZERO:   sel_ev = ev.at_zero;
            EV_PERIOD: sel_ev = ev.at_period;
            EV_CMP:    sel_ev = ev.at_cmp;
            default:   sel_ev = 1'b0;
        endcase
        evt_next = {1'b0, evt_cnt} + (EVP_W+1)'(1);
        fire     = step && sel_ev && en && (div != '0) && (evt_next >= {1'b0, div});
        soc      = soc_q && en;
    end

    always_ff @(posedge clk) begin
        if (rst || !en) begin
            evt_cnt <= '0;
        end else if (step && sel_ev && (div != '0)) begin
            evt_cnt <= fire ? '0 : evt_next[EVP_W-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (rst)       soc_q <= 1'b0;
        else if (tick) soc_q <= fire;
    end

    // R10: disabled trigger clears the event count
    assert_evt_clear_R10: assert property (@(posedge clk) disable iff (rst)
        !en |=> (evt_cnt == '0));

    // R9: a pulse starts only on a tick edge and lasts until the next tick
    assert_pulse_on_tick_R9: assert property (@(posedge clk) disable iff (rst)
        $rose(soc_q) |-> $past(tick));

    assert_pulse_hold_R9: assert property (@(posedge clk) disable iff (rst)
        !$past(tick) |-> $stable(soc_q));

    // R8: a zero prescale never starts a pulse
    assert_no_fire_div0_R8: assert property (@(posedge clk) disable iff (rst)
        (tick && div == '0) |=> !soc_q);

endmodule

// File: rtl/pwm_soc_timebase.sv
module pwm_soc_timebase
    import pwm_soc_pkg::*;
#(
    parameter int CNT_W = 16,
    parameter int HS_W  = 3,
    parameter int GEN_W = 3,
    parameter int EVP_W = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [CNT_W-1:0] period_i,
    input  logic [CNT_W-1:0] cmp_i,
    input  logic             mode_i,
    input  logic [HS_W-1:0]  hs_div_i,
    input  logic [GEN_W-1:0] gen_div_i,
    input  logic             trig_en_i,
    input  logic [1:0]       trig_src_i,
    input  logic [EVP_W-1:0] trig_div_i,
    output logic             pwm_o,
    output logic             soc_o
);
    logic       tick;
    logic       step;
    logic       run;
    tb_events_t ev;

    assign run = (tb_mode_e'(mode_i) == TB_UP);

    tb_prescaler #(.HS_W(HS_W), .GEN_W(GEN_W)) u_pre (
        .clk     (clk),
        .rst     (rst),
        .hs_sel  (hs_div_i),
        .gen_sel (gen_div_i),
        .tick    (tick)
    );

    tb_counter #(.CNT_W(CNT_W)) u_cnt (
        .clk        (clk),
        .rst        (rst),
        .tick       (tick),
        .run        (run),
        .period     (period_i),
        .cmp_shadow (cmp_i),
        .step       (step),
        .ev         (ev)
    );

    tb_action u_act (
        .clk     (clk),
        .rst     (rst),
        .step    (step),
        .at_zero (ev.at_zero),
        .at_cmp  (ev.at_cmp),
        .pwm     (pwm_o)
    );

    tb_soc_gen #(.EVP_W(EVP_W)) u_soc (
        .clk  (clk),
        .rst  (rst),
        .tick (tick),
        .step (step),
        .ev   (ev),
        .en   (trig_en_i),
        .src  (trig_src_i),
        .div  (trig_div_i),
        .soc  (soc_o)
    );

    // R2: in freeze the output level is held
    assert_freeze_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !run |=> $stable(pwm_o));

    // R9: the trigger is silent while disabled
    assert_soc_gated_R9: assert property (@(posedge clk) disable iff (rst)
        !trig_en_i |-> !soc_o);

endmodule

// File: tb/pwm_soc_timebase_tb_top.sv
module pwm_soc_timebase_tb_top;
    localparam int CNT_W = 16;
    localparam int HS_W  = 3;
    localparam int GEN_W = 3;
    localparam int EVP_W = 2;
    localparam int NPER  = 12;

    logic             clk = 1'b0;
    logic             rst = 1'b1;
    logic [CNT_W-1:0] period_i = 16'd3;
    logic [CNT_W-1:0] cmp_i = 16'd2;
    logic             mode_i = 1'b1;
    logic [HS_W-1:0]  hs_div_i = '0;
    logic [GEN_W-1:0] gen_div_i = '0;
    logic             trig_en_i = 1'b0;
    logic [1:0]       trig_src_i = 2'd0;
    logic [EVP_W-1:0] trig_div_i = 2'd1;
    logic             pwm_o;
    logic             soc_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #5 clk = ~clk;

    pwm_soc_timebase #(.CNT_W(CNT_W), .HS_W(HS_W), .GEN_W(GEN_W), .EVP_W(EVP_W)) dut_i (
        .clk (clk), .rst (rst), .period_i (period_i), .cmp_i (cmp_i),
        .mode_i (mode_i), .hs_div_i (hs_div_i), .gen_div_i (gen_div_i),
        .trig_en_i (trig_en_i), .trig_src_i (trig_src_i), .trig_div_i (trig_div_i),
        .pwm_o (pwm_o), .soc_o (soc_o)
    );

    // hs, gen, period, cmp, src, trig_div, expected pwm-high, expected soc-high (over 12 periods)
    localparam int NVEC = 7;
    localparam int VEC [NVEC][8] = '{
        '{0, 0, 9, 3, 0, 1, 36, 12},
        '{1, 0, 4, 2, 1, 2, 48, 12},
        '{0, 1, 7, 5, 2, 3, 120, 8},
        '{2, 1, 3, 0, 0, 1, 0, 96},
        '{0, 0, 5, 6, 2, 1, 72, 0},
        '{1, 2, 2, 1, 0, 3, 96, 32},
        '{0, 0, 3, 2, 0, 0, 24, 0}
    };

    task automatic check(string req, int act, int exp);
        n_checks++;
        if (act != exp) begin
            n_fails++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic do_reset();
        @(negedge clk);
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wait_rise();
        // leaves the bench at the first negedge sample where pwm_o reads 1
        while (pwm_o) @(negedge clk);
        while (!pwm_o) @(negedge clk);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end

    initial begin
        int hi, sc, tb_len, h;
        // R11: reset state
        repeat (3) @(negedge clk);
        check("R11 pwm in reset", int'(pwm_o), 0);
        check("R11 soc in reset", int'(soc_o), 0);
        period_i = 16'd3; cmp_i = 16'd2; trig_en_i = 1'b1; trig_div_i = 2'd1;
        @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        check("R11 first tick is zero event: pwm", int'(pwm_o), 1);
        check("R11 first tick is zero event: soc", int'(soc_o), 1);

        // Table: R1 R3 R5 R6 R7 R8 R9
        for (int v = 0; v < NVEC; v++) begin
            rst = 1'b1;
            hs_div_i   = HS_W'(VEC[v][0]);
            gen_div_i  = GEN_W'(VEC[v][1]);
            period_i   = CNT_W'(VEC[v][2]);
            cmp_i      = CNT_W'(VEC[v][3]);
            trig_src_i = 2'(VEC[v][4]);
            trig_div_i = EVP_W'(VEC[v][5]);
            trig_en_i  = 1'b1;
            mode_i     = 1'b1;
            repeat (3) @(negedge clk);
            rst = 1'b0;
            tb_len = (VEC[v][2] + 1) * (VEC[v][0] == 0 ? 1 : 2 * VEC[v][0]) * (1 << VEC[v][1]);
            repeat (3 * tb_len + 4) @(negedge clk);
            hi = 0; sc = 0;
            for (int c = 0; c < NPER * tb_len; c++) begin
                hi += int'(pwm_o);
                sc += int'(soc_o);
                @(negedge clk);
            end
            check($sformatf("R5 R6 R1 R3 vec %0d pwm high cycles", v), hi, VEC[v][6]);
            check($sformatf("R7 R8 R9 vec %0d soc high cycles", v), sc, VEC[v][7]);
        end

        // R4: shadow compare takes effect only at the next period
        rst = 1'b1;
        hs_div_i = '0; gen_div_i = '0; period_i = 16'd9; cmp_i = 16'd3;
        trig_src_i = 2'd0; trig_div_i = 2'd1; trig_en_i = 1'b1; mode_i = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        repeat (25) @(negedge clk);
        wait_rise();
        cmp_i = 16'd6;
        h = 0;
        while (pwm_o) begin h++; @(negedge clk); end
        check("R4 current period keeps old compare", h, 3);
        wait_rise();
        h = 0;
        while (pwm_o) begin h++; @(negedge clk); end
        check("R4 next period uses new compare", h, 6);

        // R9 R10: disabled trigger is silent, count restarts on re-enable
        period_i = 16'd3; cmp_i = 16'd2; trig_div_i = 2'd2;
        trig_en_i = 1'b0;
        sc = 0;
        repeat (40) begin sc += int'(soc_o); @(negedge clk); end
        check("R9 no pulses while disabled", sc, 0);
        wait_rise();
        // just past a zero event; enable now so the next zero event is the first counted
        trig_en_i = 1'b1;
        wait_rise();
        check("R10 first zero event after enable gives no pulse", int'(soc_o), 0);
        wait_rise();
        check("R10 second zero event gives a pulse", int'(soc_o), 1);
        @(negedge clk);
        check("R9 pulse lasts one timebase cycle", int'(soc_o), 0);

        // R2: freeze holds output and stops pulses
        trig_div_i = 2'd1;
        wait_rise();
        mode_i = 1'b0;
        @(negedge clk);
        hi = 0; sc = 0;
        repeat (50) begin hi += int'(pwm_o); sc += int'(soc_o); @(negedge clk); end
        check("R2 pwm held high in freeze", hi, 50);
        check("R2 no pulses in freeze", sc, 0);
        mode_i = 1'b1;
        repeat (40) @(negedge clk);
        hi = 0;
        repeat (40) begin hi += int'(pwm_o); @(negedge clk); end
        check("R2 resumes counting after freeze", hi, 20);

        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fails);
        $finish;
    end
endmodule